// File: doc/BRIEF.md
# Dual-Protocol Register Access Port

This block is the slave side of a host control link. A host writes and reads a bank of 8-bit control and status registers over one of two serial protocols. A level input chooses which one is live. There is a 4-wire synchronous serial link (SPI), clock-polarity 1 and clock-phase 1, framed by an active-low select. There is also a two-wire I2C bus, where the slave answers to an address that a 2-bit strap input picks. Both selection inputs act at once: they are resynchronised to the system clock and never held.

All bus pins are oversampled by the system clock through a short synchroniser chain. Edges are found in the clock domain. Register accesses leave the block as single-cycle write and read strobes, with an address and write data. The register file returns read data in the same cycle as the read strobe. In both protocols the register address advances by one after every data byte and wraps from the last register (49) back to 0.

Some I2C addresses are broadcast group addresses, used to write the same data into several slaves. A read aimed at a group address is refused without touching any state.

Top module: `hostlink_port`

## Requirements
- R1: With `proto_sel`=0 only the SPI engine may produce strobes or drive `spi_miso`. With `proto_sel`=1 only the I2C engine may produce strobes or pull `i2c_sda_oe`. Activity on the unselected protocol's pins writes nothing and acknowledges nothing.
- R2: SPI uses clock-polarity 1 and clock-phase 1. `spi_mosi` is sampled on the rising edge of `spi_sck`. `spi_miso` changes after the falling edge. Every byte travels MSB first.
- R3: An SPI frame opens with a command byte: bit 7 = 1 for read, 0 for write; bit 6 is ignored; bits 5:0 hold the start address. In a write frame each following byte is written to the start address, then to start+1, and so on. A write strobe and a read strobe are never high in the same cycle.
- R4: In an SPI read frame each following byte returns the register at the start address, then start+1, and so on. Raising `spi_csn` ends the frame, and the next frame starts over with a command byte.
- R5: The I2C individual address is 0x60 for `addr_sel`=00, 0x61 for 10 or 11, and 0x62 for 01. The matching group address is 0x70, 0x71 or 0x72. A byte carrying any other address is not acknowledged and causes no strobe.
- R6: An I2C write acknowledges the address byte (R/W bit 0 = write). It then acknowledges a subaddress byte, whose bits 5:0 set the register address. Each data byte after that is acknowledged and written to consecutive addresses.
- R7: An I2C read (R/W bit 1) to the individual address is acknowledged. The slave then returns registers from the current address onward, MSB first. It continues while the master acknowledges and releases SDA after a master NACK.
- R8: A group address with a write is handled like the individual address. A group address with a read is not acknowledged, issues no read strobe and leaves the register address unchanged.
- R9: The register address wraps from 49 to 0 in both protocols. A start address or subaddress above 49 is taken as 0. No strobe ever carries an address above 49.
- R10: An I2C STOP returns the slave to idle. A repeated START opens a new address phase and keeps the register address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all bus pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| proto_sel | input | 1 | 0 = SPI, 1 = I2C; followed continuously |
| addr_sel | input | 2 | I2C address strap: 00 low, 10/11 mid, 01 high |
| spi_csn | input | 1 | SPI select, active low |
| spi_sck | input | 1 | SPI clock, idles high |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host, 0 when idle |
| i2c_scl | input | 1 | I2C clock |
| i2c_sda_in | input | 1 | I2C data line as seen on the bus |
| i2c_sda_oe | output | 1 | 1 = pull SDA low (open drain) |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_addr | output | 6 | Register address for the strobe |
| reg_wdata | output | 8 | Write data for the strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle of `reg_rd` |

## Verification
Each pin is seen about three system cycles after it changes: two synchroniser stages and one edge register. Strobes fire in the cycle the edge is detected. `spi_miso` and `i2c_sda_oe` settle one cycle later, so about four cycles after the bus clock edge. The bench holds every bus half-period for eight or more system cycles. It reads `spi_miso` and the SDA line just before the next rising bus-clock edge, well past that latency. Register-file effects are checked after the frame or STOP has completed.

// File: rtl/hl_pkg.sv
package hl_pkg;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 8;
  localparam int REG_LAST = 49;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  // next register address with wrap at the last implemented register
  function automatic addr_t next_addr(input addr_t a);
    return (a >= addr_t'(REG_LAST)) ? addr_t'(0) : addr_t'(a + addr_t'(1));
  endfunction

  // out-of-range start addresses fold to zero
  function automatic addr_t clamp_addr(input addr_t a);
    return (a > addr_t'(REG_LAST)) ? addr_t'(0) : a;
  endfunction

  // strap level to address offset: 00 low, 01 high, 10/11 mid
  function automatic logic [6:0] sel_offset(input logic [1:0] sel);
    case (sel)
      2'b00:   return 7'd0;
      2'b01:   return 7'd2;
      default: return 7'd1;
    endcase
  endfunction
endpackage

// File: rtl/hl_sync_edge.sv
module hl_sync_edge #(
  parameter int          W      = 8,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST;
      prev <= RST;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/hl_spi_engine.sv
module hl_spi_engine
  import hl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  csn,
  input  logic  sck_rise,
  input  logic  sck_fall,
  input  logic  mosi,
  input  data_t rdata,
  output logic  wr,
  output logic  rd,
  output addr_t addr,
  output data_t wdata,
  output logic  miso
);
  logic [2:0] bit_q;
  logic       first_q, rw_q, miso_q;
  data_t      sh_q, tx_q;
  addr_t      addr_q;
  logic       active, byte_done;

  assign active    = en & ~csn;
  assign wdata     = {sh_q[DATA_W-2:0], mosi};
  assign byte_done = active & sck_rise & (bit_q == 3'd7);
  assign wr        = byte_done & ~first_q & ~rw_q;
  // read data fetched on the first falling edge of each data byte
  assign rd        = active & sck_fall & (bit_q == 3'd0) & ~first_q & rw_q;
  assign addr      = addr_q;
  assign miso      = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0; first_q <= 1'b1; rw_q <= 1'b0; miso_q <= 1'b0;
      sh_q <= '0; tx_q <= '0; addr_q <= '0;
    end else if (!active) begin
      bit_q <= '0; first_q <= 1'b1; rw_q <= 1'b0; miso_q <= 1'b0;
      tx_q <= '0;
    end else if (sck_rise) begin
      sh_q  <= wdata;
      bit_q <= bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        if (first_q) begin
          first_q <= 1'b0;
          rw_q    <= wdata[7];
          addr_q  <= clamp_addr(wdata[ADDR_W-1:0]);
        end else if (!rw_q) begin
          addr_q <= next_addr(addr_q);
        end
      end
    end else if (sck_fall) begin
      if (rd) begin
        miso_q <= rdata[DATA_W-1];
        tx_q   <= rdata << 1;
        addr_q <= next_addr(addr_q);
      end else begin
        miso_q <= tx_q[DATA_W-1];
        tx_q   <= tx_q << 1;
      end
    end
  end
endmodule

// File: rtl/hl_i2c_engine.sv
module hl_i2c_engine
  import hl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       scl,
  input  logic       sda,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic [6:0] dev_addr,
  input  logic [6:0] grp_addr,
  input  data_t      rdata,
  output logic       wr,
  output logic       rd,
  output addr_t      addr,
  output data_t      wdata,
  output logic       sda_oe,
  output logic       grp_rd_evt
);
  typedef enum logic [2:0] {I_IDLE, I_ADDR, I_SUB, I_WDATA, I_RDATA} ist_t;
  ist_t       st_q;
  logic [3:0] cnt_q;
  data_t      sh_q, tx_q;
  logic       rw_q, ackph_q, mack_q, oe_q;
  addr_t      addr_q;
  logic       start_evt, stop_evt, recv, addr_hit, addr_end;

  assign start_evt  = en & scl & sda_fall;
  assign stop_evt   = en & scl & sda_rise;
  assign recv       = (st_q == I_ADDR) | (st_q == I_SUB) | (st_q == I_WDATA);
  assign addr_hit   = (sh_q[7:1] == dev_addr) | ((sh_q[7:1] == grp_addr) & ~sh_q[0]);
  assign addr_end   = en & scl_fall & ~ackph_q & (st_q == I_ADDR) & (cnt_q == 4'd8);
  assign grp_rd_evt = addr_end & (sh_q[7:1] == grp_addr) & sh_q[0];
  assign wr = en & scl_fall & ~ackph_q & (st_q == I_WDATA) & (cnt_q == 4'd8);
  assign rd = en & scl_fall & ((ackph_q & (st_q == I_ADDR) & rw_q) |
                               ((st_q == I_RDATA) & (cnt_q == 4'd9) & mack_q));
  assign wdata  = sh_q;
  assign addr   = addr_q;
  assign sda_oe = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= I_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      rw_q <= 1'b0; ackph_q <= 1'b0; mack_q <= 1'b0; oe_q <= 1'b0; addr_q <= '0;
    end else if (!en) begin
      st_q <= I_IDLE; cnt_q <= '0; ackph_q <= 1'b0; oe_q <= 1'b0;
    end else if (start_evt) begin
      st_q <= I_ADDR; cnt_q <= '0; ackph_q <= 1'b0; oe_q <= 1'b0; mack_q <= 1'b0;
    end else if (stop_evt) begin
      st_q <= I_IDLE; cnt_q <= '0; ackph_q <= 1'b0; oe_q <= 1'b0;
    end else if (scl_rise) begin
      if (recv && !ackph_q && cnt_q < 4'd8) begin
        sh_q  <= {sh_q[DATA_W-2:0], sda};
        cnt_q <= cnt_q + 4'd1;
      end
      if (st_q == I_RDATA && cnt_q == 4'd9) mack_q <= ~sda;
    end else if (scl_fall) begin
      if (ackph_q) begin
        ackph_q <= 1'b0; oe_q <= 1'b0; cnt_q <= '0;
        if (st_q == I_ADDR) begin
          if (rw_q) begin
            st_q   <= I_RDATA;
            tx_q   <= rdata << 1;
            oe_q   <= ~rdata[DATA_W-1];
            cnt_q  <= 4'd1;
            addr_q <= next_addr(addr_q);
          end else begin
            st_q <= I_SUB;
          end
        end else if (st_q == I_SUB) begin
          st_q <= I_WDATA;
        end
      end else begin
        case (st_q)
          I_ADDR: if (cnt_q == 4'd8) begin
            if (addr_hit) begin
              ackph_q <= 1'b1; oe_q <= 1'b1; rw_q <= sh_q[0];
            end else begin
              st_q <= I_IDLE;
            end
          end
          I_SUB: if (cnt_q == 4'd8) begin
            addr_q  <= clamp_addr(sh_q[ADDR_W-1:0]);
            ackph_q <= 1'b1; oe_q <= 1'b1;
          end
          I_WDATA: if (cnt_q == 4'd8) begin
            addr_q  <= next_addr(addr_q);
            ackph_q <= 1'b1; oe_q <= 1'b1;
          end
          I_RDATA: begin
            if (cnt_q < 4'd8) begin
              oe_q  <= ~tx_q[DATA_W-1];
              tx_q  <= tx_q << 1;
              cnt_q <= cnt_q + 4'd1;
            end else if (cnt_q == 4'd8) begin
              oe_q  <= 1'b0;
              cnt_q <= 4'd9;
            end else if (mack_q) begin
              tx_q   <= rdata << 1;
              oe_q   <= ~rdata[DATA_W-1];
              cnt_q  <= 4'd1;
              addr_q <= next_addr(addr_q);
            end else begin
              st_q <= I_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hostlink_port.sv
module hostlink_port
  import hl_pkg::*;
#(
  parameter logic [6:0] IND_BASE    = 7'h60,
  parameter logic [6:0] GRP_BASE    = 7'h70,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proto_sel,
  input  logic [1:0]        addr_sel,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              i2c_scl,
  input  logic              i2c_sda_in,
  output logic              i2c_sda_oe,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  // bit order: sel[1:0], sda, scl, mosi, sck, csn, proto
  localparam int         PIN_W   = 8;
  localparam logic [7:0] PIN_RST = 8'b0011_0111;

  logic [PIN_W-1:0] pin_q, pin_rise, pin_fall;
  logic             proto_i2c;
  logic             spi_wr, spi_rd, i2c_wr, i2c_rd, i2c_grp_rd;
  addr_t            spi_addr, i2c_addr;
  data_t            spi_wdata, i2c_wdata;
  logic [6:0]       dev_addr, grp_addr;

  hl_sync_edge #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({addr_sel, i2c_sda_in, i2c_scl, spi_mosi, spi_sck, spi_csn, proto_sel}),
    .q(pin_q), .rise(pin_rise), .fall(pin_fall)
  );

  assign proto_i2c = pin_q[0];
  assign dev_addr  = IND_BASE + sel_offset(pin_q[7:6]);
  assign grp_addr  = GRP_BASE + sel_offset(pin_q[7:6]);

  hl_spi_engine u_spi (
    .clk(clk), .rst_n(rst_n), .en(~proto_i2c), .csn(pin_q[1]),
    .sck_rise(pin_rise[2]), .sck_fall(pin_fall[2]), .mosi(pin_q[3]),
    .rdata(reg_rdata), .wr(spi_wr), .rd(spi_rd), .addr(spi_addr),
    .wdata(spi_wdata), .miso(spi_miso)
  );

  hl_i2c_engine u_i2c (
    .clk(clk), .rst_n(rst_n), .en(proto_i2c), .scl(pin_q[4]), .sda(pin_q[5]),
    .scl_rise(pin_rise[4]), .scl_fall(pin_fall[4]),
    .sda_rise(pin_rise[5]), .sda_fall(pin_fall[5]),
    .dev_addr(dev_addr), .grp_addr(grp_addr), .rdata(reg_rdata),
    .wr(i2c_wr), .rd(i2c_rd), .addr(i2c_addr), .wdata(i2c_wdata),
    .sda_oe(i2c_sda_oe), .grp_rd_evt(i2c_grp_rd)
  );

  assign reg_wr    = proto_i2c ? i2c_wr    : spi_wr;
  assign reg_rd    = proto_i2c ? i2c_rd    : spi_rd;
  assign reg_addr  = proto_i2c ? i2c_addr  : spi_addr;
  assign reg_wdata = proto_i2c ? i2c_wdata : spi_wdata;
endmodule

// File: rtl/hostlink_port_chk.sv
module hostlink_port_chk
  import hl_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        proto_i2c,
  input logic        reg_wr,
  input logic        reg_rd,
  input addr_t       reg_addr,
  input logic        spi_wr,
  input logic        spi_rd,
  input logic        i2c_wr,
  input logic        i2c_rd,
  input logic        i2c_sda_oe,
  input logic        i2c_grp_rd
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd)); // R3
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (reg_addr <= addr_t'(REG_LAST))); // R9
  AST_SPI_QUIET_IN_I2C: assert property (@(posedge clk) disable iff (!rst_n)
    proto_i2c |-> (!spi_wr && !spi_rd)); // R1
  AST_I2C_QUIET_IN_SPI: assert property (@(posedge clk) disable iff (!rst_n)
    (!proto_i2c && $past(!proto_i2c)) |-> (!i2c_wr && !i2c_rd && !i2c_sda_oe)); // R1
  AST_GROUP_READ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_grp_rd |=> !i2c_sda_oe); // R8
endmodule

bind hostlink_port hostlink_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .proto_i2c(proto_i2c),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .spi_wr(spi_wr), .spi_rd(spi_rd), .i2c_wr(i2c_wr), .i2c_rd(i2c_rd),
  .i2c_sda_oe(i2c_sda_oe), .i2c_grp_rd(i2c_grp_rd)
);

// File: tb/hostlink_port_bench.sv
`timescale 1ns/1ps
module hostlink_port_bench;
  localparam int SH = 8;   // SPI half period in clk cycles
  localparam int Q  = 8;   // I2C quarter period
  localparam int LAST = 49;

  logic clk = 1'b0, rst_n = 1'b0;
  logic proto_sel = 1'b1;
  logic [1:0] addr_sel = 2'b00;
  logic spi_csn = 1'b1, spi_sck = 1'b1, spi_mosi = 1'b0, spi_miso;
  logic scl = 1'b1, sda_m = 1'b1, sda_oe, sda_line;
  logic reg_wr, reg_rd;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [0:LAST];
  logic [7:0] exp_mem [0:LAST];
  int checks = 0, fails = 0, rd_count = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  hostlink_port u_hostlink_port (
    .clk(clk), .rst_n(rst_n), .proto_sel(proto_sel), .addr_sel(addr_sel),
    .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .i2c_scl(scl), .i2c_sda_in(sda_line), .i2c_sda_oe(sda_oe),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // bench-side register file
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= LAST; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (reg_wr && reg_addr <= 6'(LAST)) begin
      mem[reg_addr] <= reg_wdata;
    end
    if (rst_n && reg_rd) rd_count <= rd_count + 1;
  end
  assign reg_rdata = (reg_addr <= 6'(LAST)) ? mem[reg_addr] : 8'h00;

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int nxt(input int a);
    return (a >= LAST) ? 0 : a + 1;
  endfunction

  // ---------------- SPI master ----------------
  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_sck = 1'b0; spi_mosi = tx[i];
      wait_n(SH);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      wait_n(SH);
    end
  endtask

  task automatic spi_open(input logic rd, input logic [5:0] a);
    logic [7:0] dummy;
    spi_csn = 1'b0; wait_n(SH);
    spi_byte({rd, 1'b1, a}, dummy);
  endtask

  task automatic spi_close();
    wait_n(SH); spi_csn = 1'b1; wait_n(4 * SH);
  endtask

  // ---------------- I2C master ----------------
  task automatic i2c_start();
    sda_m = 1'b1; wait_n(Q); scl = 1'b1; wait_n(Q);
    sda_m = 1'b0; wait_n(Q); scl = 1'b0; wait_n(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_n(Q); scl = 1'b1; wait_n(Q);
    sda_m = 1'b1; wait_n(2 * Q);
  endtask

  task automatic i2c_clk_bit(output logic smp);
    wait_n(Q); scl = 1'b1; wait_n(Q); smp = sda_line; wait_n(Q);
    scl = 1'b0; wait_n(Q);
  endtask

  task automatic i2c_wbyte(input logic [7:0] b, output logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) begin sda_m = b[i]; i2c_clk_bit(s); end
    sda_m = 1'b1; i2c_clk_bit(nack);
  endtask

  task automatic i2c_rbyte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin sda_m = 1'b1; i2c_clk_bit(s); b[i] = s; end
    sda_m = ~give_ack; i2c_clk_bit(s);
  endtask

  task automatic i2c_write(input logic [7:0] dw, input logic [5:0] sub,
                           input logic [7:0] d, input string req);
    logic n;
    i2c_start();
    i2c_wbyte(dw, n);  chk({req, " addr ack"}, n, 0);
    i2c_wbyte({2'b00, sub}, n); chk({req, " sub ack"}, n, 0);
    i2c_wbyte(d, n);   chk({req, " data ack"}, n, 0);
    i2c_stop();
  endtask

  typedef struct packed { logic use_i2c; logic [5:0] a; logic [7:0] d; } vec_t;
  localparam vec_t VECS [6] = '{
    '{1'b0, 6'd0,  8'hA5}, '{1'b0, 6'd17, 8'h3C}, '{1'b0, 6'd49, 8'hFF},
    '{1'b1, 6'd2,  8'h81}, '{1'b1, 6'd33, 8'h00}, '{1'b1, 6'd48, 8'h5E}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] r0, r1, r2;
    logic n;
    int base_rd;
    for (int i = 0; i <= LAST; i++) exp_mem[i] = 8'(i * 7 + 3);
    wait_n(5); rst_n = 1'b1; wait_n(5);

    // reset state (R1)
    chk("R1 reset miso", spi_miso, 0);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset wr", reg_wr, 0);
    chk("R1 reset rd", reg_rd, 0);

    // table walk: write then read back through the same protocol (R2 R3 R4 R6 R7)
    for (int v = 0; v < 6; v++) begin
      if (VECS[v].use_i2c) begin
        proto_sel = 1'b1; wait_n(8);
        i2c_write(8'hC0, VECS[v].a, VECS[v].d, "R6");
        i2c_start(); i2c_wbyte(8'hC0, n); i2c_wbyte({2'b00, VECS[v].a}, n);
        i2c_start(); i2c_wbyte(8'hC1, n); chk("R7 read addr ack", n, 0);
        i2c_rbyte(1'b0, r0); i2c_stop();
        chk("R7 i2c readback", r0, VECS[v].d);
      end else begin
        proto_sel = 1'b0; wait_n(8);
        spi_open(1'b0, VECS[v].a); spi_byte(VECS[v].d, r1); spi_close();
        spi_open(1'b1, VECS[v].a); spi_byte(8'h00, r0); spi_close();
        chk("R2 R4 spi readback", r0, VECS[v].d);
      end
      exp_mem[VECS[v].a] = VECS[v].d;
      chk("R3 R6 regfile content", mem[VECS[v].a], VECS[v].d);
    end

    // SPI burst write across the wrap (R3 R9)
    proto_sel = 1'b0; wait_n(8);
    spi_open(1'b0, 6'd48);
    spi_byte(8'h11, r0); spi_byte(8'h22, r0); spi_byte(8'h33, r0);
    spi_close();
    exp_mem[48] = 8'h11; exp_mem[49] = 8'h22; exp_mem[0] = 8'h33;
    chk("R3 burst 48", mem[48], 8'h11);
    chk("R9 burst 49", mem[49], 8'h22);
    chk("R9 wrap to 0", mem[0], 8'h33);

    // SPI burst read across the wrap (R4 R9)
    spi_open(1'b1, 6'd48);
    spi_byte(8'h00, r0); spi_byte(8'h00, r1); spi_byte(8'h00, r2);
    spi_close();
    chk("R4 read 48", r0, exp_mem[48]);
    chk("R4 read 49", r1, exp_mem[49]);
    chk("R9 read wrap 0", r2, exp_mem[0]);

    // SPI start address above 49 folds to 0 (R9)
    spi_open(1'b0, 6'd55); spi_byte(8'h77, r0); spi_close();
    exp_mem[0] = 8'h77;
    chk("R9 start above last", mem[0], 8'h77);

    // SPI frame aborted mid-byte, next frame starts fresh (R4)
    spi_csn = 1'b0; wait_n(SH);
    for (int i = 0; i < 4; i++) begin
      spi_sck = 1'b0; spi_mosi = 1'b1; wait_n(SH); spi_sck = 1'b1; wait_n(SH);
    end
    spi_close();
    spi_open(1'b1, 6'd17); spi_byte(8'h00, r0); spi_close();
    chk("R4 frame after abort", r0, exp_mem[17]);

    // R1: SPI traffic ignored while I2C is selected
    proto_sel = 1'b1; wait_n(8);
    spi_open(1'b0, 6'd30); spi_byte(8'hEE, r0); spi_close();
    chk("R1 spi ignored in i2c mode", mem[30], exp_mem[30]);
    // R1: I2C traffic ignored while SPI is selected
    proto_sel = 1'b0; wait_n(8);
    i2c_start(); i2c_wbyte(8'hC0, n); i2c_stop();
    chk("R1 i2c not acked in spi mode", n, 1);
    proto_sel = 1'b1; wait_n(8);

    // I2C burst write, repeated start read keeps the address (R6 R7 R10)
    i2c_start(); i2c_wbyte(8'hC0, n); i2c_wbyte(8'd10, n);
    i2c_wbyte(8'h5A, n); i2c_wbyte(8'hC3, n); chk("R6 second data ack", n, 0);
    i2c_start(); i2c_wbyte(8'hC0, n); i2c_wbyte(8'd10, n);
    i2c_start(); i2c_wbyte(8'hC1, n); chk("R10 restart read ack", n, 0);
    i2c_rbyte(1'b1, r0); i2c_rbyte(1'b0, r1); i2c_stop();
    exp_mem[10] = 8'h5A; exp_mem[11] = 8'hC3;
    chk("R10 restart read byte0", r0, 8'h5A);
    chk("R7 read continues after ack", r1, 8'hC3);
    chk("R7 sda released after nack", sda_oe, 0);

    // I2C write wrap 49 -> 0 (R9)
    i2c_start(); i2c_wbyte(8'hC0, n); i2c_wbyte(8'd49, n);
    i2c_wbyte(8'h9A, n); i2c_wbyte(8'h9B, n); i2c_stop();
    exp_mem[49] = 8'h9A; exp_mem[0] = 8'h9B;
    chk("R9 i2c wrap", mem[0], 8'h9B);

    // address strap mapping (R5)
    addr_sel = 2'b10; wait_n(8);
    i2c_start(); i2c_wbyte(8'hC2, n); i2c_stop(); chk("R5 mid addr 0x61", n, 0);
    addr_sel = 2'b11; wait_n(8);
    i2c_start(); i2c_wbyte(8'hC2, n); i2c_stop(); chk("R5 sel 11 as mid", n, 0);
    addr_sel = 2'b01; wait_n(8);
    i2c_start(); i2c_wbyte(8'hC4, n); i2c_stop(); chk("R5 high addr 0x62", n, 0);
    i2c_start(); i2c_wbyte(8'hC0, n); i2c_stop(); chk("R5 low addr refused when high", n, 1);
    addr_sel = 2'b00; wait_n(8);
    i2c_start(); i2c_wbyte(8'hC2, n); i2c_stop(); chk("R5 wrong addr nack", n, 1);

    // group write and refused group read (R8)
    i2c_write(8'hE0, 6'd20, 8'h6B, "R8 group write");
    exp_mem[20] = 8'h6B;
    chk("R8 group write lands", mem[20], 8'h6B);
    base_rd = rd_count;
    i2c_start(); i2c_wbyte(8'hE1, n); i2c_stop();
    chk("R8 group read nack", n, 1);
    chk("R8 group read no strobe", rd_count - base_rd, 0);
    i2c_start(); i2c_wbyte(8'hC1, n); i2c_rbyte(1'b0, r0); i2c_stop();
    chk("R8 address unchanged by group read", r0, exp_mem[nxt(20)]);

    // STOP returns to idle: data clocked without START is ignored (R10)
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b0; i2c_clk_bit(n);
    end
    sda_m = 1'b1; wait_n(4 * Q);
    chk("R10 no ack outside transfer", sda_oe, 0);
    chk("R10 regfile untouched", mem[0], exp_mem[0]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule